// File: doc/BRIEF.md
# Memory and I/O Strobe Decoder

This block turns a per-cycle description of an external bus access into the active-low control strobes for that bus. The inputs say whether the cycle is valid, whether it targets memory or I/O, and whether it reads or writes. For memory cycles they also give the target area and the byte lanes. For I/O cycles they give the strobe-mode address bit. The outputs are chip selects for four memory areas, per-lane SRAM write enables, an SRAM/EPROM output enable, and I/O read and write strobes. All outputs are registered, so they appear one clock after the request, aligned with the address phase that the surrounding bus logic registers in the same way.

Area 0 has its own select output. It stands in for the row-strobe pin when that area holds non-DRAM memory. The I/O read strobe works in one of two ways, chosen by the mode address bit. With the bit at 0, separate read and write strobes are used. With the bit at 1, the read strobe becomes a data strobe for every I/O cycle, the write strobe stays idle, and the write-enable lines carry a read/not-write level. A registered drive flag tells the pad logic when to drive the strobes and when to tri-state them, for example while the bus is handed to another master.

Top module: `strobe_dec`

## Requirements
- R1: While rst_ni is low, every strobe output (cs_no, we_no, oe_no, iord_no, iowr_no) is high and drv_o is 0.
- R2: Outputs follow the inputs with exactly one clock of latency. A cycle with valid_i low gives all strobes high in the following cycle.
- R3: A valid memory cycle (is_io_i=0) drives cs_no[area_i] low and all other chip selects high. cs_no[0] is the area-0 select used for non-DRAM memory, and cs_no[1..3] select areas 1..3.
- R4: A valid memory write drives we_no[k] low exactly where lane_mask_i[k]=1. Lane 0 covers data bits 15..8 and lane 1 covers bits 7..0. oe_no stays high. A zero mask leaves all write enables high.
- R5: A valid memory read drives oe_no low and keeps every we_no high.
- R6: A valid I/O read with io_dstrobe_i=0 drives iord_no low and iowr_no high.
- R7: A valid I/O write with io_dstrobe_i=0 drives iowr_no low and keeps iord_no and every we_no high.
- R8: A valid I/O cycle with io_dstrobe_i=1 drives iord_no low for both reads and writes and keeps iowr_no high. Every we_no then reads as R/W#: high on reads and low on writes.
- R9: At most one chip select is low in any cycle, and none is low during an I/O cycle. oe_no is never low together with a write enable.
- R10: drv_o equals drive_en_i from the previous cycle. drive_en_i does not change any strobe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An access occupies this cycle |
| is_io_i | input | 1 | 1 = I/O access, 0 = memory access |
| is_write_i | input | 1 | 1 = write, 0 = read |
| area_i | input | 2 | Memory area 0..3 |
| lane_mask_i | input | 2 | Byte lanes to write; bit 0 = bits 15..8, bit 1 = bits 7..0 |
| io_dstrobe_i | input | 1 | I/O address mode bit (bit 10): 1 = data-strobe mode |
| drive_en_i | input | 1 | Bus owned; drive the strobes |
| cs_no | output | 4 | Chip selects, active low, one per area |
| we_no | output | 2 | Per-lane write enables, active low |
| oe_no | output | 1 | Output enable for SRAM/EPROM reads, active low |
| iord_no | output | 1 | I/O read strobe or data strobe, active low |
| iowr_no | output | 1 | I/O write strobe, active low |
| drv_o | output | 1 | Tri-state drive enable for all strobes |

## Verification
The assertions assume that area_i, lane_mask_i and io_dstrobe_i are only meaningful when valid_i is high. They also assume that the access type is held steady within the single cycle in which it is sampled. The scoreboard drives every input at the falling edge, so each request is one clean, fully defined cycle. It mixes memory and I/O cycles, both I/O modes, all four areas, every lane mask, idle gaps, and drive-enable toggles. Outputs are compared one rising edge after the request.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  parameter int unsigned NUM_AREAS = 4;
  parameter int unsigned NUM_LANES = 2;
  localparam int unsigned AREA_W = $clog2(NUM_AREAS);

  typedef enum logic {
    IO_SPLIT   = 1'b0,
    IO_DSTROBE = 1'b1
  } io_mode_e;
endpackage

// File: rtl/strobe_cs_dec.sv
module strobe_cs_dec
  import strobe_pkg::*;
(
  input  logic              mem_i,
  input  logic [AREA_W-1:0] area_i,
  output logic [NUM_AREAS-1:0] cs_n_o
);
  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
    assign cs_n_o[a] = !(mem_i && (area_i == AREA_W'(a)));
  end
endmodule

// File: rtl/strobe_we_dec.sv
module strobe_we_dec
  import strobe_pkg::*;
(
  input  logic                 mem_wr_i,
  input  logic                 io_dstb_i,
  input  logic                 is_write_i,
  input  logic [NUM_LANES-1:0] lane_mask_i,
  output logic [NUM_LANES-1:0] we_n_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    // data-strobe I/O mode: every lane carries R/W#
    always_comb begin
      if (mem_wr_i)       we_n_o[k] = !lane_mask_i[k];
      else if (io_dstb_i) we_n_o[k] = !is_write_i;
      else                we_n_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/strobe_io_dec.sv
module strobe_io_dec
  import strobe_pkg::*;
(
  input  logic     io_i,
  input  logic     is_write_i,
  input  io_mode_e mode_i,
  output logic     iord_n_o,
  output logic     iowr_n_o
);
  always_comb begin
    iord_n_o = 1'b1;
    iowr_n_o = 1'b1;
    if (io_i) begin
      if (mode_i == IO_DSTROBE) begin
        iord_n_o = 1'b0;
      end else begin
        iord_n_o = is_write_i;
        iowr_n_o = !is_write_i;
      end
    end
  end
endmodule

// File: rtl/strobe_dec.sv
module strobe_dec
  import strobe_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 is_io_i,
  input  logic                 is_write_i,
  input  logic [AREA_W-1:0]    area_i,
  input  logic [NUM_LANES-1:0] lane_mask_i,
  input  logic                 io_dstrobe_i,
  input  logic                 drive_en_i,
  output logic [NUM_AREAS-1:0] cs_no,
  output logic [NUM_LANES-1:0] we_no,
  output logic                 oe_no,
  output logic                 iord_no,
  output logic                 iowr_no,
  output logic                 drv_o
);
  logic mem_cyc, io_cyc, io_dstb;
  logic [NUM_AREAS-1:0] cs_d;
  logic [NUM_LANES-1:0] we_d;
  logic oe_d, iord_d, iowr_d;
  io_mode_e mode;

  assign mem_cyc = valid_i && !is_io_i;
  assign io_cyc  = valid_i && is_io_i;
  assign mode    = io_mode_e'(io_dstrobe_i);
  assign io_dstb = io_cyc && (mode == IO_DSTROBE);
  assign oe_d    = !(mem_cyc && !is_write_i);

  strobe_cs_dec u_cs (
    .mem_i  (mem_cyc),
    .area_i (area_i),
    .cs_n_o (cs_d)
  );

  strobe_we_dec u_we (
    .mem_wr_i    (mem_cyc && is_write_i),
    .io_dstb_i   (io_dstb),
    .is_write_i  (is_write_i),
    .lane_mask_i (lane_mask_i),
    .we_n_o      (we_d)
  );

  strobe_io_dec u_io (
    .io_i       (io_cyc),
    .is_write_i (is_write_i),
    .mode_i     (mode),
    .iord_n_o   (iord_d),
    .iowr_n_o   (iowr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no   <= '1;
      we_no   <= '1;
      oe_no   <= 1'b1;
      iord_no <= 1'b1;
      iowr_no <= 1'b1;
      drv_o   <= 1'b0;
    end else begin
      cs_no   <= cs_d;
      we_no   <= we_d;
      oe_no   <= oe_d;
      iord_no <= iord_d;
      iowr_no <= iowr_d;
      drv_o   <= drive_en_i;
    end
  end

  AST_CS_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);  // R9
  AST_IO_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_io_i) |=> (&cs_no));  // R9
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (&we_no));  // R5
  AST_IO_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!iord_no && !iowr_no));  // R7
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (&cs_no && &we_no && oe_no && iord_no && iowr_no));  // R2
  AST_DSTB_NO_IOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_io_i && io_dstrobe_i) |=> (iowr_no && !iord_no));  // R8
  AST_DRV_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_i |=> drv_o);  // R10
endmodule

// File: tb/sim_strobe_dec.sv
`timescale 1ns/1ps
module sim_strobe_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, is_io = 1'b0, is_wr = 1'b0, dstb = 1'b0, den = 1'b0;
  logic [1:0] area = '0;
  logic [1:0] mask = '0;
  logic [3:0] cs_n;
  logic [1:0] we_n;
  logic oe_n, iord_n, iowr_n, drv;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [9:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  strobe_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .is_io_i(is_io),
    .is_write_i(is_wr), .area_i(area), .lane_mask_i(mask),
    .io_dstrobe_i(dstb), .drive_en_i(den), .cs_no(cs_n), .we_no(we_n),
    .oe_no(oe_n), .iord_no(iord_n), .iowr_no(iowr_n), .drv_o(drv)
  );

  function automatic logic [9:0] observed();
    return {drv, cs_n, we_n, oe_n, iord_n, iowr_n};
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle at the falling edge and push the expected result
  task automatic drive(bit v, bit io, bit wr, logic [1:0] ar, logic [1:0] mk,
                       bit ds, bit de, string tag);
    logic [3:0] e_cs = 4'hF;
    logic [1:0] e_we = 2'b11;
    logic e_oe = 1'b1, e_rd = 1'b1, e_wr = 1'b1;
    @(negedge clk);
    valid = v; is_io = io; is_wr = wr; area = ar; mask = mk; dstb = ds; den = de;
    if (v && !io) begin
      e_cs[ar] = 1'b0;
      if (wr) e_we = ~mk;
      else    e_oe = 1'b0;
    end else if (v && io) begin
      if (ds) begin
        e_rd = 1'b0;
        e_we = wr ? 2'b00 : 2'b11;
      end else if (wr) e_wr = 1'b0;
      else             e_rd = 1'b0;
    end
    exp_q.push_back({de, e_cs, e_we, e_oe, e_rd, e_wr});
    tag_q.push_back(tag);
  endtask

  // monitor: one item per cycle, compared just after the registering edge
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, observed(), e);
    end
  end

  initial begin
    #3;
    check("R1 reset", observed(), 10'b0_1111_11_1_1_1);
    repeat (2) @(negedge clk);
    check("R1 reset held", observed(), 10'b0_1111_11_1_1_1);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    for (int a = 0; a < 4; a++) drive(1, 0, 0, 2'(a), 2'b11, 0, 1, "R3 R5 mem read area");
    for (int m = 0; m < 4; m++) drive(1, 0, 1, 2'(m), 2'(m), 0, 1, "R4 mem write lanes");
    drive(0, 1, 1, 3, 3, 1, 1, "R2 idle with junk inputs");
    drive(1, 1, 0, 0, 0, 0, 1, "R6 io read split");
    drive(1, 1, 1, 2, 3, 0, 1, "R7 io write split");
    drive(1, 1, 0, 1, 0, 1, 1, "R8 io read dstrobe");
    drive(1, 1, 1, 3, 0, 1, 1, "R8 io write dstrobe");
    drive(1, 1, 1, 1, 3, 1, 0, "R9 R10 io dstrobe undriven");
    drive(1, 0, 1, 2, 2'b01, 0, 0, "R10 mem write undriven");
    drive(1, 0, 0, 3, 0, 1, 1, "R5 mem read mode bit ignored");
    drive(1, 1, 1, 0, 0, 0, 0, "R7 back-to-back io write");
    drive(0, 0, 0, 0, 0, 0, 1, "R2 return high");
    for (int i = 0; i < 32; i++)
      drive(i[0], i[1], i[2], 2'(i >> 3), 2'(i + 1), i[4], i[3], "R2 R9 mixed");
    drive(0, 0, 0, 0, 0, 0, 0, "R2 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule